// File: doc/BRIEF.md
# DDR3 Mode-Register Initialization Sequencer

This block brings a DDR3 memory device to a usable state after reset. A single-cycle start pulse makes it request power-up from the memory controller and wait for the power-up-done status. The wait is bounded: the bound is a parameter given in clock cycles, and when it runs out the sequence stops with an error flag set. Once power-up is confirmed, the block sends a fixed series of seven commands through one command word, and each command addresses both chip-selects.

The series is: deselect, precharge of all banks, four mode-register writes, and a long ZQ calibration. The mode-register writes go in the order MR2, MR3, MR1, MR0. The payloads are computed inside the block from three inputs: write recovery, CAS latency and CAS write latency.

Every command is presented with its start bit set. The start bit stays up until the controller reports that the command is finished. The start bit then drops for one cycle before the next command is presented. After the last command completes, a done flag is raised. The done flag or the error flag stays set until the next start pulse.

Top module: `ddr3_mrs_seq`

## Requirements
- R1: After reset, pwr_req_o, cmd_o, done_o and err_o are all zero.
- R2: A start pulse seen in the idle, done or failed state raises pwr_req_o on the next clock edge and clears done_o and err_o. pwr_req_o stays high until pwr_done_i is sampled high. No command is presented while pwr_req_o is high.
- R3: Cycles in the power-up wait are numbered from 0, beginning with the cycle that follows the start edge. If pwr_done_i is not sampled high in any of the first TIMEOUT_CYCLES of these cycles, then one edge later err_o rises and pwr_req_o falls. After that, a late pwr_done_i starts no command.
- R4: When power-up is confirmed, seven commands follow, each addressed to both ranks, in this order: deselect (code 0x0), precharge-all (code 0x1), mode write of MR2, mode write of MR3, mode write of MR1, mode write of MR0 (code 0x3 for all four), and ZQ calibration long (code 0x5).
- R5: A presented command word has its start flag at bit 31 and both rank selects at bits 21:20 set to 11. The mode-register number sits at bits 19:17 and the 13-bit payload at bits 16:4; both fields are zero for commands that are not mode writes. The command code sits at bits 3:0, and all other bits are zero.
- R6: A presented word is held unchanged until cmd_done_i is sampled high. On the next edge cmd_o becomes all zero for one cycle, and the next command follows on the edge after that.
- R7: The MR0 payload bits 11:9 encode write recovery n. First, n above 8 is rounded up to the next even value. The field is then n-4 when n is 8 or less, and otherwise (n>>1)&7.
- R8: The MR0 payload bits 6:4 hold (c-4)&7 for CAS latency c, and bit 2 holds bit 3 of (c-4). All other MR0 bits are zero.
- R9: The MR1 payload is 0x040, selecting 120 ohm termination. The MR2 payload has ((w-5)&7) at bits 5:3 for CAS write latency w, with its other bits zero. The MR3 payload is zero.
- R10: The edge that samples cmd_done_i high for the ZQ calibration command raises done_o. done_o and err_o are never high together, and each holds until the next start pulse.
- R11: A start pulse that arrives while power-up or the command series is in progress has no effect on pwr_req_o, on the order or content of the commands, or on completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for the bring-up sequence |
| twr_i | input | 5 | Write recovery in clock cycles |
| tcl_i | input | 5 | CAS latency in clock cycles |
| tcwl_i | input | 5 | CAS write latency in clock cycles |
| pwr_done_i | input | 1 | Power-up finished status |
| cmd_done_i | input | 1 | Current command finished (start bit cleared by the controller) |
| pwr_req_o | output | 1 | Power-up request |
| cmd_o | output | 32 | Command word |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Power-up timeout |

## Verification
Each result has a fixed delay after the stimulus that causes it:
- pwr_req_o is due one edge after the start pulse.
- The first command word is due one edge after pwr_done_i is sampled.
- The zero gap is due one edge after each cmd_done_i, and the next word one edge later.
- done_o is due one edge after the final acknowledge.
- err_o is due at cycle TIMEOUT_CYCLES of the power-up wait.

The bench drives its inputs on falling edges and samples the outputs on the following falling edge, so each result is checked half a cycle after the edge that produces it. The power-up wait is checked at both edges of its window: done in the last allowed cycle must succeed, and no done at all must fail exactly one cycle later. Acknowledge delays are drawn at random, and the bench checks that the word stays stable in every cycle it waits.

// File: rtl/ddr3_seq_pkg.sv
package ddr3_seq_pkg;

    localparam int WORD_W    = 32;
    localparam int START_BIT = 31;
    localparam int RANK_LSB  = 20;
    localparam int MRN_LSB   = 17;
    localparam int MRN_W     = 3;
    localparam int DATA_LSB  = 4;
    localparam int DATA_W    = 13;
    localparam int OP_W      = 4;
    localparam int NUM_STEPS = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_ISSUE,
        ST_GAP,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [OP_W-1:0] {
        OP_DESEL = 4'h0,
        OP_PREA  = 4'h1,
        OP_MRS   = 4'h3,
        OP_ZQCL  = 4'h5
    } cmd_op_t;

endpackage

// File: rtl/ddr3_mr_encoder.sv
module ddr3_mr_encoder
    import ddr3_seq_pkg::*;
#(
    parameter int TW = 5
) (
    input  logic [TW-1:0]     twr_i,
    input  logic [TW-1:0]     tcl_i,
    input  logic [TW-1:0]     tcwl_i,
    output logic [DATA_W-1:0] mr0_o,
    output logic [DATA_W-1:0] mr1_o,
    output logic [DATA_W-1:0] mr2_o,
    output logic [DATA_W-1:0] mr3_o
);

    logic [TW:0] twr_ext;
    logic [TW:0] twr_adj;
    logic [2:0]  wr_field;
    logic [3:0]  cl_sub;
    logic [2:0]  cwl_field;

    always_comb begin
        twr_ext = {1'b0, twr_i};
        if (twr_ext > (TW+1)'(8))
            twr_adj = (twr_ext + (TW+1)'(1)) & ~((TW+1)'(1));
        else
            twr_adj = twr_ext;

        if (twr_adj <= (TW+1)'(8))
            wr_field = 3'(twr_adj - (TW+1)'(4));
        else
            wr_field = 3'(twr_adj >> 1);

        cl_sub    = 4'(tcl_i - TW'(4));
        cwl_field = 3'(tcwl_i - TW'(5));

        mr0_o       = '0;
        mr0_o[11:9] = wr_field;
        mr0_o[6:4]  = cl_sub[2:0];
        mr0_o[2]    = cl_sub[3];

        mr1_o       = '0;
        mr1_o[6]    = 1'b1;

        mr2_o       = '0;
        mr2_o[5:3]  = cwl_field;

        mr3_o       = '0;
    end

    // R7: an even write-recovery setting must not be altered by rounding
    always_comb begin
        if (twr_i > TW'(8) && twr_i[0] == 1'b0)
            a_r7_even_kept: assert (twr_adj == twr_ext);
    end

endmodule

// File: rtl/ddr3_cmd_word.sv
module ddr3_cmd_word
    import ddr3_seq_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic              issue_i,
    input  logic [IW-1:0]     step_i,
    input  logic [DATA_W-1:0] mr0_i,
    input  logic [DATA_W-1:0] mr1_i,
    input  logic [DATA_W-1:0] mr2_i,
    input  logic [DATA_W-1:0] mr3_i,
    output logic [WORD_W-1:0] word_o
);

    cmd_op_t           op;
    logic [MRN_W-1:0]  mr_num;
    logic [DATA_W-1:0] payload;

    always_comb begin
        op      = OP_DESEL;
        mr_num  = '0;
        payload = '0;
        case (step_i)
            IW'(0): op = OP_DESEL;
            IW'(1): op = OP_PREA;
            IW'(2): begin op = OP_MRS; mr_num = MRN_W'(2); payload = mr2_i; end
            IW'(3): begin op = OP_MRS; mr_num = MRN_W'(3); payload = mr3_i; end
            IW'(4): begin op = OP_MRS; mr_num = MRN_W'(1); payload = mr1_i; end
            IW'(5): begin op = OP_MRS; mr_num = MRN_W'(0); payload = mr0_i; end
            IW'(6): op = OP_ZQCL;
            default: op = OP_DESEL;
        endcase

        word_o = '0;
        if (issue_i) begin
            word_o[START_BIT]            = 1'b1;
            word_o[RANK_LSB +: 2]        = 2'b11;
            word_o[MRN_LSB +: MRN_W]     = mr_num;
            word_o[DATA_LSB +: DATA_W]   = payload;
            word_o[OP_W-1:0]             = op;
        end
    end

endmodule

// File: rtl/ddr3_seq_ctrl.sv
module ddr3_seq_ctrl
    import ddr3_seq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 25_000_000,
    parameter int STEPS          = NUM_STEPS,
    localparam int IW            = $clog2(STEPS),
    localparam int CW            = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          pwr_done_i,
    input  logic          cmd_done_i,
    output logic          issue_o,
    output logic [IW-1:0] step_o,
    output logic          pwr_req_o,
    output logic          done_o,
    output logic          err_o
);

    localparam logic [CW-1:0] CNT_LAST  = CW'(TIMEOUT_CYCLES - 1);
    localparam logic [IW-1:0] STEP_LAST = IW'(STEPS - 1);

    typedef struct packed {
        seq_state_t    st;
        logic [IW-1:0] step;
        logic [CW-1:0] cnt;
        logic          done;
        logic          err;
    } ctrl_t;

    localparam ctrl_t RESET_VAL = '{st: ST_IDLE, step: '0, cnt: '0, done: 1'b0, err: 1'b0};

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    r_d.st   = ST_PWR;
                    r_d.cnt  = '0;
                    r_d.step = '0;
                    r_d.done = 1'b0;
                    r_d.err  = 1'b0;
                end
            end
            ST_PWR: begin
                if (pwr_done_i) begin
                    r_d.st   = ST_ISSUE;
                    r_d.step = '0;
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.st  = ST_FAIL;
                    r_d.err = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_ISSUE: begin
                if (cmd_done_i) begin
                    if (r_q.step == STEP_LAST) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                r_d.st   = ST_ISSUE;
                r_d.step = r_q.step + IW'(1);
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign issue_o   = (r_q.st == ST_ISSUE);
    assign step_o    = r_q.step;
    assign pwr_req_o = (r_q.st == ST_PWR);
    assign done_o    = r_q.done;
    assign err_o     = r_q.err;

    // R10: completion and failure flags never coexist
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R10: done holds until a new start
    a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o);

    // R2: no command while power-up is pending
    a_r2_no_cmd_in_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req_o |-> !issue_o);

    // R6: presented command held until acknowledged
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o && !cmd_done_i |=> issue_o && $stable(step_o));

    // R6: acknowledge opens a gap cycle
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o && cmd_done_i |=> !issue_o);

    // R3: a failed sequence presents no command
    a_r3_no_cmd_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !issue_o && !pwr_req_o);

    // R3: the wait counter stays inside its window
    a_r3_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req_o |-> r_q.cnt <= CNT_LAST);

    // R11: a start pulse mid-sequence does not restart power-up
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o || r_q.st == ST_GAP) |=> !pwr_req_o);

endmodule

// File: rtl/ddr3_mrs_seq.sv
module ddr3_mrs_seq
    import ddr3_seq_pkg::*;
#(
    parameter int TW             = 5,
    parameter int TIMEOUT_CYCLES = 25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TW-1:0]     twr_i,
    input  logic [TW-1:0]     tcl_i,
    input  logic [TW-1:0]     tcwl_i,
    input  logic              pwr_done_i,
    input  logic              cmd_done_i,
    output logic              pwr_req_o,
    output logic [WORD_W-1:0] cmd_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int IW = $clog2(NUM_STEPS);

    logic              issue;
    logic [IW-1:0]     step;
    logic [DATA_W-1:0] mr0, mr1, mr2, mr3;

    ddr3_seq_ctrl #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
        .STEPS         (NUM_STEPS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .pwr_done_i(pwr_done_i),
        .cmd_done_i(cmd_done_i),
        .issue_o   (issue),
        .step_o    (step),
        .pwr_req_o (pwr_req_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    ddr3_mr_encoder #(.TW(TW)) u_enc (
        .twr_i (twr_i),
        .tcl_i (tcl_i),
        .tcwl_i(tcwl_i),
        .mr0_o (mr0),
        .mr1_o (mr1),
        .mr2_o (mr2),
        .mr3_o (mr3)
    );

    ddr3_cmd_word #(.IW(IW)) u_word (
        .issue_i(issue),
        .step_i (step),
        .mr0_i  (mr0),
        .mr1_i  (mr1),
        .mr2_i  (mr2),
        .mr3_i  (mr3),
        .word_o (cmd_o)
    );

    // R5: a presented word always addresses both ranks
    a_r5_both_ranks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[START_BIT] |-> cmd_o[RANK_LSB +: 2] == 2'b11);

endmodule

// File: tb/ddr3_mrs_seq_tb.sv
`timescale 1ns/1ps
module ddr3_mrs_seq_tb;

    localparam int TO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  twr_i = 5'd6, tcl_i = 5'd6, tcwl_i = 5'd5;
    logic        pwr_done_i = 1'b0;
    logic        cmd_done_i = 1'b0;
    logic        pwr_req_o;
    logic [31:0] cmd_o;
    logic        done_o, err_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ddr3_mrs_seq #(.TW(5), .TIMEOUT_CYCLES(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .twr_i(twr_i), .tcl_i(tcl_i), .tcwl_i(tcwl_i),
        .pwr_done_i(pwr_done_i), .cmd_done_i(cmd_done_i),
        .pwr_req_o(pwr_req_o), .cmd_o(cmd_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int f_mr0(int twr, int tcl);
        int w = twr;
        int wf, c;
        if (w > 8) w = (w + 1) & ~1;
        wf = (w <= 8) ? (w - 4) : ((w >> 1) & 7);
        c = tcl - 4;
        return (wf << 9) | ((c & 7) << 4) | (((c >> 3) & 1) << 2);
    endfunction

    function automatic int f_word(int k, int twr, int tcl, int tcwl);
        int op, mrn, dat;
        op = 3; mrn = 0; dat = 0;
        case (k)
            0: op = 0;
            1: op = 1;
            2: begin mrn = 2; dat = ((tcwl - 5) & 7) << 3; end
            3: begin mrn = 3; dat = 0; end
            4: begin mrn = 1; dat = 'h40; end
            5: begin mrn = 0; dat = f_mr0(twr, tcl); end
            default: op = 5;
        endcase
        return (1 << 31) | (3 << 20) | (mrn << 17) | (dat << 4) | op;
    endfunction

    function automatic string f_tag(int k);
        case (k)
            0, 1, 6: return "R4";
            2:       return "R9 mr2";
            3:       return "R9 mr3";
            4:       return "R9 mr1";
            default: return "R7 R8 mr0";
        endcase
    endfunction

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_ok(input int twr, input int tcl, input int tcwl,
                          input int pdly, input bit inject, input bit rnd_ack);
        twr_i = 5'(twr); tcl_i = 5'(tcl); tcwl_i = 5'(tcwl);
        @(negedge clk);
        pulse_start();
        chk("R2 req after start", {31'd0, pwr_req_o}, 32'd1);
        chk("R2 flags cleared", {30'd0, done_o, err_o}, 32'd0);
        for (int j = 0; j < pdly; j++) begin
            if (inject && j == 0) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk("R2 req held, no cmd", {pwr_req_o, cmd_o[31]}, {1'b1, 1'b0});
        end
        pwr_done_i = 1'b1;
        @(negedge clk);
        pwr_done_i = 1'b0;
        chk("R2 req released", {31'd0, pwr_req_o}, 32'd0);
        for (int k = 0; k < 7; k++) begin
            int ad;
            logic [31:0] exp;
            exp = 32'(f_word(k, twr, tcl, tcwl));
            chk(f_tag(k), cmd_o, exp);
            ad = rnd_ack ? int'($urandom_range(0, 2)) : 0;
            if (inject && k == 2) begin
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk("R11 start ignored", cmd_o, exp);
                chk("R11 no power req", {31'd0, pwr_req_o}, 32'd0);
            end
            for (int a = 0; a < ad; a++) begin
                @(negedge clk);
                chk("R6 word held", cmd_o, exp);
            end
            cmd_done_i = 1'b1;
            @(negedge clk);
            cmd_done_i = 1'b0;
            if (k < 6) begin
                chk("R6 gap zero", cmd_o, 32'd0);
                @(negedge clk);
            end
        end
        chk("R10 done raised", {30'd0, done_o, err_o}, 32'd2);
        chk("R10 cmd idle", cmd_o, 32'd0);
        repeat (4) @(negedge clk);
        chk("R10 done held", {30'd0, done_o, err_o}, 32'd2);
    endtask

    task automatic run_timeout();
        @(negedge clk);
        pulse_start();
        for (int j = 0; j < TO; j++) begin
            if (j == TO - 1) chk("R3 still waiting at last cycle",
                                 {30'd0, pwr_req_o, err_o}, 32'd2);
            @(negedge clk);
        end
        chk("R3 timeout error", {29'd0, pwr_req_o, done_o, err_o}, 32'd1);
        pwr_done_i = 1'b1;
        @(negedge clk);
        pwr_done_i = 1'b0;
        @(negedge clk);
        chk("R3 late done ignored", cmd_o, 32'd0);
        chk("R3 error held", {30'd0, done_o, err_o}, 32'd1);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {cmd_o[31:3], pwr_req_o, done_o, err_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", cmd_o, 32'd0);

        run_ok(8, 12, 5, TO - 1, 1'b1, 1'b1);
        run_ok(9, 11, 8, 0, 1'b0, 1'b0);
        run_timeout();
        run_ok(16, 16, 12, 3, 1'b0, 1'b1);
        run_ok(12, 5, 10, 1, 1'b1, 1'b0);
        run_ok(5, 8, 7, 2, 1'b0, 1'b1);
        for (int r = 0; r < 6; r++)
            run_ok(int'($urandom_range(5, 16)), int'($urandom_range(5, 16)),
                   int'($urandom_range(5, 12)), int'($urandom_range(0, 10)),
                   1'($urandom_range(0, 1)), 1'b1);
        run_timeout();
        run_ok(10, 14, 9, 5, 1'b0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule